// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives words over a half-duplex synchronous serial link while acting as the clock master. It produces the shift clock on `ckOut` from a programmable divider and takes the data line `dtIn` once per bit, at the edge where the clock goes back to its idle level. Words are 8 or 9 bits long and arrive least significant bit first. Each complete word goes into a small receive buffer. Software reads that buffer through a read strobe.

Software starts reception in one of two ways. A one-shot strobe arms single-word reception, and the arm clears itself once that word is taken in. A level-held continuous enable keeps words coming back to back until software drops it. If both are active, the continuous enable wins. Dropping the continuous enable also clears the overrun error. No clocks are produced while the port enable is low.

Top module: `syncMasterRx`

## Requirements
- R1: After reset, `rxDone`, `overrun`, `irq` and `singleBusy` are 0 and `ckOut` equals `polSel`.
- R2: While `portEn` is 0, no clock edges appear on `ckOut` and it stays at `polSel`, even if an enable is asserted.
- R3: A `singleSet` pulse with `portEn`=1 receives exactly one word and then stops the clock. `singleBusy` drops in the same cycle that `rxDone` rises.
- R4: While `contEn` is 1, words are received back to back, each with the correct value, until `contEn` is cleared.
- R5: When `contEn` and a single arm are both active, reception continues after the first word.
- R6: `ckOut` idles at `polSel`. Each bit is sampled when `ckOut` returns to its idle level. Bits arrive LSB first, with bit k of the word on the k-th clock.
- R7: With `nineBit`=1, the ninth received bit appears on `rxBit9`. With `nineBit`=0, `rxBit9` reads 0 and 8-bit words are received.
- R8: `rxDone` is 1 whenever the buffer holds at least one word, and `irq` equals `rxDone` AND `intEn`.
- R9: The clock spends D+1 cycles in each level. D is `{divHigh,divLow}` when `wide16`=1 and `divLow` alone when `wide16`=0, in which case `divHigh` is ignored.
- R10: The buffer holds two words in arrival order. A `rdStrobe` pops the head, and `rxDone` clears only when the buffer is empty.
- R11: If a word completes while the buffer is full, `overrun` goes to 1, that word is discarded and clocking stops. `overrun` returns to 0 in the cycle after `contEn` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portEn | input | 1 | Serial port enabled in master synchronous mode |
| polSel | input | 1 | Idle level of ckOut |
| nineBit | input | 1 | 9-bit word mode |
| wide16 | input | 1 | Use the 16-bit divider |
| divLow | input | 8 | Divider low byte |
| divHigh | input | 8 | Divider high byte |
| singleSet | input | 1 | One-cycle strobe arming single-word reception |
| contEn | input | 1 | Continuous reception enable |
| intEn | input | 1 | Receive interrupt enable |
| rdStrobe | input | 1 | Pops the head of the receive buffer |
| dtIn | input | 1 | Serial data line |
| ckOut | output | 1 | Generated shift clock |
| rxData | output | 8 | Head word, low 8 bits |
| rxBit9 | output | 1 | Head word, ninth bit |
| rxDone | output | 1 | Receive-complete flag |
| overrun | output | 1 | Overrun error flag |
| irq | output | 1 | Receive interrupt |
| singleBusy | output | 1 | Single-word arm still pending |

## Verification
The overrun case is the hardest to reach from the ports. The buffer must already be full when a third word finishes, and that word must then be shown to have been dropped. The bench gets there by holding the continuous enable high with three different words queued on the data line and issuing no reads. Once `overrun` rises, it confirms that the clock has stopped. It then pops both stored words, checks that the buffer reads empty, and only after that drops the enable to clear the flag.

// File: rtl/syncMasterRxPkg.sv
package syncMasterRxPkg;
  localparam int IDX_W = 4;
  typedef struct packed {
    logic             sampleBit;
    logic             wordDone;
    logic [IDX_W-1:0] bitIdx;
  } rxStrobes_t;
endpackage

// File: rtl/syncMasterRxCtrl.sv
module syncMasterRxCtrl
  import syncMasterRxPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              contEn,
  input  logic              singleSet,
  input  logic              nineBit,
  input  logic              wide16,
  input  logic [BYTE_W-1:0] divLow,
  input  logic [BYTE_W-1:0] divHigh,
  input  logic              overrunIn,
  input  logic              fullIn,
  output rxStrobes_t        st,
  output logic              phase,
  output logic              singleBusy
);
  localparam int DIV_W = 2 * BYTE_W;

  logic              active;
  logic [DIV_W-1:0]  halfCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [DIV_W-1:0]  divVal;
  logic [IDX_W-1:0]  lastIdx;
  logic              enAny;
  logic              edgeNow;

  assign divVal  = wide16 ? {divHigh, divLow} : {{BYTE_W{1'b0}}, divLow};
  assign lastIdx = nineBit ? IDX_W'(BYTE_W) : IDX_W'(BYTE_W - 1);
  assign enAny   = portEn && (contEn || singleBusy);
  assign edgeNow = active && enAny && (halfCnt == '0);

  always_comb begin
    st.sampleBit = edgeNow && phase;
    st.wordDone  = edgeNow && phase && (bitIdx == lastIdx);
    st.bitIdx    = bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleBusy <= 1'b0;
    end else if (!portEn || st.wordDone) begin
      singleBusy <= 1'b0;
    end else if (singleSet) begin
      singleBusy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (!active) begin
      phase   <= 1'b0;
      halfCnt <= divVal;
      bitIdx  <= '0;
      active  <= enAny && !overrunIn;
    end else if (!enAny) begin
      active <= 1'b0;
      phase  <= 1'b0;
    end else if (halfCnt == '0) begin
      halfCnt <= divVal;
      phase   <= ~phase;
      if (phase) begin
        if (bitIdx == lastIdx) begin
          bitIdx <= '0;
          active <= contEn && !fullIn;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end else begin
      halfCnt <= halfCnt - 1'b1;
    end
  end

  // R2
  port_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> !phase);

  // R3
  single_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wordDone && !contEn) |=> !singleBusy);

  // R11
  overrun_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && overrunIn) |=> !active);
endmodule

// File: rtl/syncMasterRxData.sv
module syncMasterRxData
  import syncMasterRxPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        st,
  input  logic              dtIn,
  input  logic              nineBit,
  input  logic              contEn,
  input  logic              rdStrobe,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              overrun,
  output logic              full
);
  localparam int WORD_W = BYTE_W + 1;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] shiftQ, nextShift, pushWord;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              push, pop;

  always_comb begin
    nextShift = shiftQ;
    if (st.sampleBit) nextShift[st.bitIdx] = dtIn;
    pushWord = {nineBit ? nextShift[WORD_W-1] : 1'b0, nextShift[BYTE_W-1:0]};
  end

  assign full   = (count == CNT_W'(DEPTH));
  assign push   = st.wordDone && !full && !overrun;
  assign pop    = rdStrobe && (count != '0);
  assign rxDone = (count != '0);
  assign rxData = mem[rdPtr][BYTE_W-1:0];
  assign rxBit9 = mem[rdPtr][WORD_W-1];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (st.wordDone) begin
      shiftQ <= '0;
    end else begin
      shiftQ <= nextShift;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mem[i] <= '0;
        else if (push && (wrPtr == PTR_W'(i))) mem[i] <= pushWord;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (!contEn) overrun <= 1'b0;
      else if (st.wordDone && full) overrun <= 1'b1;
    end
  end

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R11
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> (count <= $past(count)));

  // R8
  done_from_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(st.wordDone));
endmodule

// File: rtl/syncMasterRx.sv
module syncMasterRx
  import syncMasterRxPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              polSel,
  input  logic              nineBit,
  input  logic              wide16,
  input  logic [BYTE_W-1:0] divLow,
  input  logic [BYTE_W-1:0] divHigh,
  input  logic              singleSet,
  input  logic              contEn,
  input  logic              intEn,
  input  logic              rdStrobe,
  input  logic              dtIn,
  output logic              ckOut,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              overrun,
  output logic              irq,
  output logic              singleBusy
);
  rxStrobes_t st;
  logic       phase;
  logic       full;

  syncMasterRxCtrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .portEn(portEn), .contEn(contEn),
    .singleSet(singleSet), .nineBit(nineBit), .wide16(wide16),
    .divLow(divLow), .divHigh(divHigh), .overrunIn(overrun),
    .fullIn(full), .st(st), .phase(phase), .singleBusy(singleBusy)
  );

  syncMasterRxData #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .st(st), .dtIn(dtIn), .nineBit(nineBit),
    .contEn(contEn), .rdStrobe(rdStrobe), .rxData(rxData),
    .rxBit9(rxBit9), .rxDone(rxDone), .overrun(overrun), .full(full)
  );

  assign ckOut = phase ^ polSel;
  assign irq   = rxDone & intEn;
endmodule

// File: tb/syncMasterRx_tb.sv
module syncMasterRx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portEn = 1'b0, polSel = 1'b0, nineBit = 1'b0, wide16 = 1'b0;
  logic [7:0] divLow = 8'd0, divHigh = 8'd0;
  logic singleSet = 1'b0, contEn = 1'b0, intEn = 1'b0, rdStrobe = 1'b0;
  logic dtIn = 1'b0;
  logic ckOut, rxBit9, rxDone, overrun, irq, singleBusy;
  logic [7:0] rxData;

  int checks = 0, failures = 0;
  int cycle = 0;
  logic [8:0] txWords [4];
  int txIdx = 0, wordPtr = 0, nBits = 8;
  int rises = 0, lastRise = 0, riseGap = 0;
  logic prevPh = 1'b0;

  syncMasterRx dut_i (
    .clk(clk), .rstN(rstN), .portEn(portEn), .polSel(polSel),
    .nineBit(nineBit), .wide16(wide16), .divLow(divLow), .divHigh(divHigh),
    .singleSet(singleSet), .contEn(contEn), .intEn(intEn),
    .rdStrobe(rdStrobe), .dtIn(dtIn), .ckOut(ckOut), .rxData(rxData),
    .rxBit9(rxBit9), .rxDone(rxDone), .overrun(overrun), .irq(irq),
    .singleBusy(singleBusy)
  );

  always #10 clk = ~clk;

  // slave model: new bit on each clock move away from idle
  always @(negedge clk) begin
    logic ph;
    cycle++;
    ph = ckOut ^ polSel;
    if (ph && !prevPh) begin
      riseGap = cycle - lastRise;
      lastRise = cycle;
      rises++;
      dtIn = txWords[wordPtr % 4][txIdx];
      txIdx++;
      if (txIdx == nBits) begin
        txIdx = 0;
        wordPtr++;
      end
    end
    prevPh = ph;
    if (cycle > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    for (int i = 0; i < limit && !rxDone; i++) @(negedge clk);
  endtask

  task automatic armTx(input int bits);
    nBits = bits;
    txIdx = 0;
    wordPtr = 0;
  endtask

  task automatic idleRises(input string req, input int span);
    int r0;
    r0 = rises;
    repeat (span) @(negedge clk);
    check(req, rises - r0, 0);
  endtask

  task automatic singleWord(input logic [8:0] w, input int bits, input string req);
    txWords[0] = w;
    armTx(bits);
    pulse(singleSet);
    waitDone(20000);
    check(req, {rxBit9, rxData}, (bits == 9) ? w : {1'b0, w[7:0]});
    check("R3 busy", singleBusy, 0);
    pulse(rdStrobe);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", rxDone, 0);
    check("R1 ovr", overrun, 0);
    check("R1 irq", irq, 0);
    check("R1 busy", singleBusy, 0);
    check("R1 ck", ckOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 disabled port produces no clocks for either polarity
    for (int p = 0; p < 2; p++) begin
      polSel = p[0];
      contEn = 1'b1;
      @(negedge clk);
      idleRises("R2 rises", 40);
      check("R2 ck idle", ckOut, p[0]);
      contEn = 1'b0;
    end
    @(negedge clk);
    portEn = 1'b1;

    // R6/R7 sweep of all byte values, both polarities, 8-bit mode
    for (int p = 0; p < 2; p++) begin
      polSel = p[0];
      @(negedge clk);
      check("R6 idle", ckOut, p[0]);
      for (int v = 0; v < 256; v++) singleWord(9'(v), 8, "R6 R7 byte");
    end
    polSel = 1'b0;

    // R3 exactly one word then silence
    idleRises("R3 stop", 60);

    // R7 nine-bit sweep
    nineBit = 1'b1;
    for (int v = 0; v < 512; v += 37) singleWord(9'(v), 9, "R7 nine");
    singleWord(9'h1FF, 9, "R7 nine top");
    singleWord(9'h100, 9, "R7 nine bit only");
    nineBit = 1'b0;

    // R8 interrupt gating
    txWords[0] = 9'h5A;
    armTx(8);
    pulse(singleSet);
    waitDone(2000);
    check("R8 irq off", irq, 0);
    intEn = 1'b1;
    @(negedge clk);
    check("R8 irq on", irq, 1);
    pulse(rdStrobe);
    check("R8 irq clear", irq, 0);
    check("R8 done clear", rxDone, 0);
    intEn = 1'b0;

    // R9 divider sweep: 8-bit mode ignores high byte, 16-bit uses it
    for (int d = 0; d < 6; d++) begin
      divLow = 8'(d);
      divHigh = 8'hA5;
      wide16 = 1'b0;
      singleWord(9'h3C, 8, "R9 data");
      check("R9 gap8", riseGap, 2 * (d + 1));
    end
    divLow = 8'd2;
    divHigh = 8'd1;
    wide16 = 1'b1;
    singleWord(9'hC3, 8, "R9 data16");
    check("R9 gap16", riseGap, 2 * (258 + 1));
    wide16 = 1'b0;
    divLow = 8'd1;
    divHigh = 8'd0;

    // R4 continuous, read promptly
    txWords[0] = 9'h11; txWords[1] = 9'h22; txWords[2] = 9'h33; txWords[3] = 9'h44;
    armTx(8);
    contEn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      waitDone(2000);
      check("R4 word", rxData, {4'(k + 1), 4'(k + 1)});
      pulse(rdStrobe);
    end
    contEn = 1'b0;
    @(negedge clk);
    idleRises("R4 stop", 40);
    if (rxDone) pulse(rdStrobe);
    check("R4 empty", rxDone, 0);

    // R5 both enables: continuous wins
    txWords[0] = 9'hA1; txWords[1] = 9'hB2;
    armTx(8);
    contEn = 1'b1;
    pulse(singleSet);
    waitDone(2000);
    check("R5 first", rxData, 8'hA1);
    pulse(rdStrobe);
    waitDone(2000);
    check("R5 second", rxData, 8'hB2);
    contEn = 1'b0;
    pulse(rdStrobe);
    @(negedge clk);
    if (rxDone) pulse(rdStrobe);

    // R10 and R11: fill the buffer, third word overruns
    txWords[0] = 9'h0F; txWords[1] = 9'hF0; txWords[2] = 9'h99;
    armTx(8);
    contEn = 1'b1;
    for (int i = 0; i < 4000 && !overrun; i++) @(negedge clk);
    check("R11 set", overrun, 1);
    idleRises("R11 halted", 60);
    check("R10 head", rxData, 8'h0F);
    pulse(rdStrobe);
    check("R10 still done", rxDone, 1);
    check("R10 second", rxData, 8'hF0);
    pulse(rdStrobe);
    check("R11 discarded", rxDone, 0);
    check("R11 held", overrun, 1);
    contEn = 1'b0;
    @(negedge clk);
    check("R11 cleared", overrun, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule